// File: doc/BRIEF.md
# Interrupt Distributor Register Front-End

This block is the register face of a simplified interrupt distributor. Software reaches it through a 32-bit word bus: a byte offset, write data, a single write strobe and a combinational read-data return. Inside are a global control word and read-only type and identification words. There are also enable and pending bitmaps for the shared interrupts, which software changes through separate set and clear windows, and a byte-per-interrupt priority store. Several windows answer with a fixed pattern and drop every write.

Only the group-1 enable bit of the control word is writable. The routing and single-security mode bits are tied high. The type word is derived at elaboration from the configured interrupt count. The first 32 interrupt slots of every per-interrupt window are reserved for private interrupts handled elsewhere, so they read zero and ignore writes. Priorities are stored only; no arbitration happens here.

Top module: `irq_dist_regs`

## Requirements
- R1: In the control word (offset 0x000), bit 4 (affinity routing) and bit 6 (single security state) always read 1, and bit 0 (group-0 enable) always reads 0. Writes do not change any of them.
- R2: Control bit 1 (group-1 enable) reads back the value last written to it. It is 0 after reset.
- R3: The type word (offset 0x004) reads min(NUM_IRQ,1024)/32-1 in bits [4:0] and 9 in bits [23:19]. All other bits read 0, and writes are ignored.
- R4: The identification word (offset 0x008) reads PRODUCT_CODE in bits [31:24] and IMPL_CODE in bits [11:0], and ignores writes.
- R5: Writing to the enable-set window (0x100 + 4k) sets each enable bit whose data bit is 1. Writing to the enable-clear window (0x180 + 4k) clears each such bit. Zero data bits leave the bitmap alone. Both windows read the current enable bits, with bit j of word k standing for interrupt 32k+j.
- R6: The pending-set (0x200 + 4k) and pending-clear (0x280 + 4k) windows act on the pending bitmap in the same way as R5, without touching the enable bitmap.
- R7: Word 0 of each of the four set and clear windows covers interrupts 0-31. It reads 0, and writing it changes nothing.
- R8: Group words 0x080 + 4k with k < NUM_IRQ/32 read all ones and ignore writes. The active windows 0x300-0x3FF read 0 and ignore writes.
- R9: The priority of interrupt i sits at byte offset 0x400 + i, in bits [8(i%4)+7 : 8(i%4)] of its word. Bytes for i < 32 read 0 and ignore writes. Bytes for 32 <= i < NUM_IRQ read back as written.
- R10: In the identification area 0xFFD0-0xFFFC, the word at 0xFFE8 reads 0x3B and every other word reads 0. Writes are ignored.
- R11: Any other offset reads 0, and a write to it changes no state. This includes bitmap and group words for k >= NUM_IRQ/32 and priority bytes for i >= NUM_IRQ.
- R12: Reset clears the group-1 enable, both bitmaps and all stored priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte offset of the access; bits [1:0] ignored |
| wr_en | input | 1 | Write strobe, commits wr_data at the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |

## Verification
The hardest thing to show from the ports is that a write to a dead location has no side effect. A write to a reserved low word, an out-of-range bitmap word, a priority byte past the last interrupt or an unmapped offset leaves nothing to read back at its own address. The stimulus therefore first loads a known pattern into a live neighbouring word. It then aims all-ones writes at the dead locations and reads the neighbour again. It also clears and sets overlapping bit patterns through the two windows of one bitmap, and finally resets in mid-run to confirm that every stored field returns to zero.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   localparam int MAX_IRQ = 1024;

   // control word bit positions
   localparam int CTRL_G0    = 0;
   localparam int CTRL_G1    = 1;
   localparam int CTRL_ROUTE = 4;
   localparam int CTRL_ONESEC = 6;

   localparam logic [31:0] PIDR2_VAL = 32'h0000_003B;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_CTRL,
      RG_TYPE,
      RG_IDENT,
      RG_GROUP,
      RG_EN_SET,
      RG_EN_CLR,
      RG_PD_SET,
      RG_PD_CLR,
      RG_ACTIVE,
      RG_PRIO,
      RG_IDREG
   } region_e;

   function automatic logic [31:0] type_word(input int n);
      logic [31:0] v;
      int capped;
      capped  = (n > MAX_IRQ) ? MAX_IRQ : n;
      v       = '0;
      v[4:0]  = 5'((capped / 32) - 1);
      v[23:19] = 5'd9;
      return v;
   endfunction

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
   import irqd_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [4:0]        bm_idx,
   output logic [7:0]        pr_idx,
   output logic              is_pidr2
);

   localparam int HI_W = ADDR_W - 7;

   logic [HI_W-1:0]     hi;
   logic [ADDR_W-3:0]   word;
   logic                unused_lsb;

   assign hi         = addr[ADDR_W-1:7];
   assign word       = addr[ADDR_W-1:2];
   assign bm_idx     = addr[6:2];
   assign pr_idx     = addr[9:2];
   assign is_pidr2   = (addr[5:2] == 4'hA);
   assign unused_lsb = ^addr[1:0];

   always_comb begin
      region = RG_NONE;
      if (word == (ADDR_W-2)'(0))
         region = RG_CTRL;
      else if (word == (ADDR_W-2)'(1))
         region = RG_TYPE;
      else if (word == (ADDR_W-2)'(2))
         region = RG_IDENT;
      else if (hi == HI_W'(1))
         region = RG_GROUP;
      else if (hi == HI_W'(2))
         region = RG_EN_SET;
      else if (hi == HI_W'(3))
         region = RG_EN_CLR;
      else if (hi == HI_W'(4))
         region = RG_PD_SET;
      else if (hi == HI_W'(5))
         region = RG_PD_CLR;
      else if (hi == HI_W'(6) || hi == HI_W'(7))
         region = RG_ACTIVE;
      else if (addr[ADDR_W-1:10] == (ADDR_W-10)'(1))
         region = RG_PRIO;
      else if ((&addr[ADDR_W-1:6]) && (addr[5:4] != 2'b00))
         region = RG_IDREG;
   end

endmodule

// File: rtl/irqd_bitmap_bank.sv
module irqd_bitmap_bank
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ = 96
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic [4:0]         idx,
   input  logic [31:0]        wdata,
   output logic [31:0]        rd_word,
   output logic [NUM_IRQ-1:0] bits
);

   localparam int NW = NUM_IRQ / 32;
   localparam int MAX_W = MAX_IRQ / 32;

   logic [MAX_IRQ-1:0] flat;

   for (genvar w = 0; w < MAX_W; w++) begin : g_word
      if (w >= 1 && w < NW) begin : g_live
         logic [31:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (set_we && idx == 5'(w))
               q <= q | wdata;
            else if (clr_we && idx == 5'(w))
               q <= q & ~wdata;
         end
         assign flat[w*32 +: 32] = q;
      end else begin : g_dead
         assign flat[w*32 +: 32] = 32'h0;
      end
   end

   assign rd_word = flat[{idx, 5'b00000} +: 32];
   assign bits    = flat[NUM_IRQ-1:0];

endmodule

// File: rtl/irqd_prio_store.sv
module irqd_prio_store
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ = 96
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [7:0]  idx,
   input  logic [31:0] wdata,
   output logic [31:0] rd_word
);

   localparam int MAX_PW = MAX_IRQ / 4;

   logic [8*MAX_IRQ-1:0] flat;

   for (genvar wi = 0; wi < MAX_PW; wi++) begin : g_pword
      for (genvar b = 0; b < 4; b++) begin : g_lane
         localparam int IRQ = 4 * wi + b;
         if (IRQ >= 32 && IRQ < NUM_IRQ) begin : g_live
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (we && idx == 8'(wi))
                  q <= wdata[8*b +: 8];
            end
            assign flat[8*IRQ +: 8] = q;
         end else begin : g_dead
            assign flat[8*IRQ +: 8] = 8'h00;
         end
      end
   end

   assign rd_word = flat[{idx, 5'b00000} +: 32];

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
   import irqd_pkg::*;
#(
   parameter int          NUM_IRQ      = 96,
   parameter int          ADDR_W       = 16,
   parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
   parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data
);

   localparam int          NW        = NUM_IRQ / 32;
   localparam logic [31:0] TYPE_VAL  = type_word(NUM_IRQ);
   localparam logic [31:0] IDENT_VAL = {PRODUCT_CODE, 12'h000, IMPL_CODE};

   if (NUM_IRQ % 32 != 0) begin : g_chk_mult
      $error("NUM_IRQ must be a multiple of 32");
   end
   if (NUM_IRQ < 64 || NUM_IRQ > MAX_IRQ) begin : g_chk_range
      $error("NUM_IRQ must lie between 64 and 1024");
   end
   if (ADDR_W < 16) begin : g_chk_addr
      $error("ADDR_W must be at least 16");
   end

   region_e            region;
   logic [4:0]         bm_idx;
   logic [7:0]         pr_idx;
   logic               is_pidr2;
   logic               g1_en;
   logic [31:0]        en_word, pend_word, prio_word;
   logic [NUM_IRQ-1:0] en_bits, pend_bits;

   irqd_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (addr),
      .region   (region),
      .bm_idx   (bm_idx),
      .pr_idx   (pr_idx),
      .is_pidr2 (is_pidr2)
   );

   irqd_bitmap_bank #(.NUM_IRQ(NUM_IRQ)) u_enable (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (wr_en && region == RG_EN_SET),
      .clr_we  (wr_en && region == RG_EN_CLR),
      .idx     (bm_idx),
      .wdata   (wr_data),
      .rd_word (en_word),
      .bits    (en_bits)
   );

   irqd_bitmap_bank #(.NUM_IRQ(NUM_IRQ)) u_pending (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (wr_en && region == RG_PD_SET),
      .clr_we  (wr_en && region == RG_PD_CLR),
      .idx     (bm_idx),
      .wdata   (wr_data),
      .rd_word (pend_word),
      .bits    (pend_bits)
   );

   irqd_prio_store #(.NUM_IRQ(NUM_IRQ)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en && region == RG_PRIO),
      .idx     (pr_idx),
      .wdata   (wr_data),
      .rd_word (prio_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         g1_en <= 1'b0;
      else if (wr_en && region == RG_CTRL)
         g1_en <= wr_data[CTRL_G1];
   end

   always_comb begin
      rd_data = 32'h0;
      unique case (region)
         RG_CTRL: begin
            rd_data[CTRL_G1]     = g1_en;
            rd_data[CTRL_ROUTE]  = 1'b1;
            rd_data[CTRL_ONESEC] = 1'b1;
            rd_data[CTRL_G0]     = 1'b0;
         end
         RG_TYPE:   rd_data = TYPE_VAL;
         RG_IDENT:  rd_data = IDENT_VAL;
         RG_GROUP:  rd_data = (int'(bm_idx) < NW) ? 32'hFFFF_FFFF : 32'h0;
         RG_EN_SET, RG_EN_CLR: rd_data = en_word;
         RG_PD_SET, RG_PD_CLR: rd_data = pend_word;
         RG_PRIO:   rd_data = prio_word;
         RG_IDREG:  rd_data = is_pidr2 ? PIDR2_VAL : 32'h0;
         default:   rd_data = 32'h0;
      endcase
   end

endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
   parameter int NUM_IRQ = 96,
   parameter int ADDR_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr,
   input logic               wr_en,
   input logic [31:0]        wr_data,
   input logic [31:0]        rd_data,
   input logic               g1_en,
   input logic [NUM_IRQ-1:0] en_bits,
   input logic [NUM_IRQ-1:0] pend_bits
);

   localparam int NW = NUM_IRQ / 32;
   localparam int CAP = (NUM_IRQ > 1024) ? 1024 : NUM_IRQ;
   localparam logic [31:0] TYPE_EXP = (32'(CAP / 32 - 1)) | (32'd9 << 19);

   logic is_ctrl, is_grp_live, is_pend_win;
   assign is_ctrl     = (addr[ADDR_W-1:2] == '0);
   assign is_grp_live = (addr[ADDR_W-1:7] == (ADDR_W-7)'(1)) && (int'(addr[6:2]) < NW);
   assign is_pend_win = (addr[ADDR_W-1:8] == (ADDR_W-8)'(2));

   AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      is_ctrl |-> (rd_data[4] && rd_data[6] && !rd_data[0]));  // R1

   AST_G1_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_ctrl) |=> (g1_en == $past(wr_data[1])));  // R2

   AST_TYPE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[ADDR_W-1:2] == (ADDR_W-2)'(1)) |-> (rd_data == TYPE_EXP));  // R3

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[ADDR_W-1:2] == (ADDR_W-2)'('h41))
      |=> ((en_bits[63:32] & $past(wr_data)) == $past(wr_data)));  // R5

   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[ADDR_W-1:2] == (ADDR_W-2)'('h61))
      |=> ((en_bits[63:32] & $past(wr_data)) == 32'h0));  // R5

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && is_pend_win) |=> $stable(pend_bits));  // R6

   AST_LOW_WORD_WI: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[ADDR_W-1:2] == (ADDR_W-2)'('h40)) |=> $stable(en_bits));  // R7

   AST_GROUP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      is_grp_live |-> (rd_data == 32'hFFFF_FFFF));  // R8

   AST_PIDR2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[ADDR_W-1:2] == {(ADDR_W-6)'('1), 4'hA}) |-> (rd_data == 32'h3B));  // R10

endmodule

bind irq_dist_regs irq_dist_regs_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;

   typedef struct packed {
      logic        wr;
      logic [3:0]  req;
      logic [15:0] addr;
      logic [31:0] data;   // write data, or expected read value
   } vec_t;

   localparam int NV = 59;

   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'd12, 16'h0000, 32'h0000_0050},  // R12 reset state of control
      '{1'b1, 4'd2,  16'h0000, 32'hFFFF_FFFF},
      '{1'b0, 4'd1,  16'h0000, 32'h0000_0052},  // R1 R2
      '{1'b1, 4'd2,  16'h0000, 32'h0000_0000},
      '{1'b0, 4'd2,  16'h0000, 32'h0000_0050},  // R2
      '{1'b0, 4'd3,  16'h0004, 32'h0048_0002},  // R3
      '{1'b1, 4'd3,  16'h0004, 32'hFFFF_FFFF},
      '{1'b0, 4'd3,  16'h0004, 32'h0048_0002},  // R3
      '{1'b0, 4'd4,  16'h0008, 32'h4B00_043B},  // R4
      '{1'b1, 4'd4,  16'h0008, 32'h0000_0000},
      '{1'b0, 4'd4,  16'h0008, 32'h4B00_043B},  // R4
      '{1'b1, 4'd5,  16'h0104, 32'h0000_00F0},
      '{1'b0, 4'd5,  16'h0104, 32'h0000_00F0},  // R5
      '{1'b0, 4'd5,  16'h0184, 32'h0000_00F0},  // R5
      '{1'b1, 4'd5,  16'h0184, 32'h0000_0030},
      '{1'b0, 4'd5,  16'h0104, 32'h0000_00C0},  // R5
      '{1'b1, 4'd5,  16'h0108, 32'h8000_0001},
      '{1'b0, 4'd5,  16'h0188, 32'h8000_0001},  // R5
      '{1'b1, 4'd7,  16'h0100, 32'hFFFF_FFFF},
      '{1'b0, 4'd7,  16'h0100, 32'h0000_0000},  // R7
      '{1'b0, 4'd7,  16'h0180, 32'h0000_0000},  // R7
      '{1'b1, 4'd6,  16'h0204, 32'hA5A5_A5A5},
      '{1'b1, 4'd6,  16'h0284, 32'h0000_00FF},
      '{1'b0, 4'd6,  16'h0204, 32'hA5A5_A500},  // R6
      '{1'b0, 4'd6,  16'h0104, 32'h0000_00C0},  // R6 enables untouched
      '{1'b1, 4'd7,  16'h0200, 32'hFFFF_FFFF},
      '{1'b0, 4'd7,  16'h0200, 32'h0000_0000},  // R7
      '{1'b1, 4'd7,  16'h0280, 32'hFFFF_FFFF},
      '{1'b0, 4'd7,  16'h0280, 32'h0000_0000},  // R7
      '{1'b0, 4'd8,  16'h0080, 32'hFFFF_FFFF},  // R8
      '{1'b1, 4'd8,  16'h0084, 32'h0000_0000},
      '{1'b0, 4'd8,  16'h0084, 32'hFFFF_FFFF},  // R8
      '{1'b0, 4'd11, 16'h008C, 32'h0000_0000},  // R11 group word past range
      '{1'b1, 4'd8,  16'h0304, 32'hFFFF_FFFF},
      '{1'b0, 4'd8,  16'h0304, 32'h0000_0000},  // R8
      '{1'b0, 4'd8,  16'h0384, 32'h0000_0000},  // R8
      '{1'b1, 4'd9,  16'h0420, 32'h1122_3344},
      '{1'b0, 4'd9,  16'h0420, 32'h1122_3344},  // R9
      '{1'b1, 4'd9,  16'h0400, 32'hFFFF_FFFF},
      '{1'b0, 4'd9,  16'h0400, 32'h0000_0000},  // R9
      '{1'b1, 4'd9,  16'h041C, 32'hFFFF_FFFF},
      '{1'b0, 4'd9,  16'h041C, 32'h0000_0000},  // R9
      '{1'b1, 4'd9,  16'h045C, 32'hDEAD_BEEF},
      '{1'b0, 4'd9,  16'h045C, 32'hDEAD_BEEF},  // R9
      '{1'b1, 4'd11, 16'h0460, 32'hFFFF_FFFF},
      '{1'b0, 4'd11, 16'h0460, 32'h0000_0000},  // R11
      '{1'b0, 4'd10, 16'hFFE8, 32'h0000_003B},  // R10
      '{1'b0, 4'd10, 16'hFFD0, 32'h0000_0000},  // R10
      '{1'b1, 4'd10, 16'hFFE8, 32'h0000_0000},
      '{1'b0, 4'd10, 16'hFFE8, 32'h0000_003B},  // R10
      '{1'b0, 4'd10, 16'hFFFC, 32'h0000_0000},  // R10
      '{1'b1, 4'd11, 16'h000C, 32'hFFFF_FFFF},
      '{1'b0, 4'd11, 16'h000C, 32'h0000_0000},  // R11
      '{1'b1, 4'd11, 16'h010C, 32'hFFFF_FFFF},
      '{1'b0, 4'd11, 16'h010C, 32'h0000_0000},  // R11
      '{1'b0, 4'd11, 16'h0104, 32'h0000_00C0},  // R11 neighbour intact
      '{1'b1, 4'd11, 16'h0800, 32'hFFFF_FFFF},
      '{1'b0, 4'd11, 16'h0800, 32'h0000_0000},  // R11
      '{1'b0, 4'd11, 16'h0420, 32'h1122_3344}   // R11 priorities intact
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   irq_dist_regs u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   task automatic do_write(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      addr    = a;
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic do_read(input logic [15:0] a, input logic [31:0] exp, input int req);
      @(negedge clk);
      addr  = a;
      wr_en = 1'b0;
      #1;
      checks++;
      if (rd_data !== exp) begin
         fails++;
         $display("FAIL R%0d addr=%h actual=%h expected=%h", req, a, rd_data, exp);
      end
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr)
            do_write(VECS[i].addr, VECS[i].data);
         else
            do_read(VECS[i].addr, VECS[i].data, int'(VECS[i].req));
      end

      // R2: set group-1 enable again, then R12: reset mid-run clears everything
      do_write(16'h0000, 32'h0000_0002);
      do_read(16'h0000, 32'h0000_0052, 2);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_read(16'h0000, 32'h0000_0050, 12);  // R12 group-1 enable cleared
      do_read(16'h0104, 32'h0000_0000, 12);  // R12 enable bitmap cleared
      do_read(16'h0188, 32'h0000_0000, 12);  // R12
      do_read(16'h0204, 32'h0000_0000, 12);  // R12 pending bitmap cleared
      do_read(16'h0420, 32'h0000_0000, 12);  // R12 priorities cleared
      do_read(16'h045C, 32'h0000_0000, 12);  // R12

      // R5 R6: the same word in both bitmaps with overlapping set and clear
      do_write(16'h0208, 32'hFFFF_0000);
      do_write(16'h0288, 32'h00FF_FF00);
      do_read(16'h0208, 32'hFF00_0000, 6);   // R6
      do_read(16'h0108, 32'h0000_0000, 5);   // R5 enables unaffected

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule